// File: doc/BRIEF.md
# Hardware Reset Pulse Qualifier

This block sits behind the active-low hardware reset pin of a storage device's host interface. It samples the pin with a fast reference clock and filters out short pulses of either polarity. When a real reset pulse ends, it raises a single-cycle trigger that starts the device's internal reset sequence. The trigger fires on the end of the filtered low period, when the pin returns high, and never on the low level itself.

After the filtered pin goes high, the block holds a command-ready output low until two things have happened. A minimum wait, 200 us by default, must have elapsed on the reference clock. The host bus clock must also have produced a minimum number of rising edges, 74 by default. Another qualified low pulse during this wait clears both counts, and they start again from zero. All thresholds are given in nanoseconds or in cycle counts, and the block converts them to reference clock cycles at elaboration.

Top module: `hw_reset_qualifier`

## Requirements
- R1: While rst_ni is low, reset_trigger_o and cmd_ready_o are both 0.
- R2: A low pulse on rst_pin_ni of 5 ns, or of fewer than FILT_CYC reference cycles (4 by default), is ignored. No trigger occurs, and cmd_ready_o stays 1 if it was 1.
- R3: A high pulse of 5 ns on rst_pin_ni while the pin is held low produces no trigger. Only the final qualified release produces one.
- R4: A low pulse of 1 us or longer produces exactly one reset_trigger_o pulse, exactly one reference cycle wide, within 8 reference cycles after the pin returns high.
- R5: No trigger is produced while the pin is held low, however long the low lasts.
- R6: With the bus clock running, cmd_ready_o rises only after the filtered pin has been high for WAIT_NS converted to reference cycles (2000 cycles in the bench), and not before.
- R7: With the timer expired, cmd_ready_o stays 0 after BUS_CYCLES-1 bus clock rising edges and goes to 1 after the BUS_CYCLES-th edge.
- R8: A qualified low pulse during the post-release wait restarts both the timer and the bus edge count.
- R9: A qualified low pulse drops cmd_ready_o to 0 within a few reference cycles. While the filtered pin is low, cmd_ready_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference sampling clock |
| rst_ni | input | 1 | Block asynchronous reset, active low |
| rst_pin_ni | input | 1 | Raw asynchronous hardware reset pin, active low |
| bus_clk_i | input | 1 | Host bus clock, sampled by clk_i |
| reset_trigger_o | output | 1 | One-cycle pulse on a qualified release of the pin |
| cmd_ready_o | output | 1 | High once the post-reset wait and the bus clock count are complete |

## Verification
A filter counter that is stuck or miscounted shows up as a missing or extra trigger pulse within about eight reference cycles of a pin edge. It can also show as cmd_ready_o dropping after a glitch. A wrong wait timer moves the rise of cmd_ready_o to a different cycle after release, so it is checked in a window on both sides of that cycle. A bus edge counter that is off by one shows as cmd_ready_o rising one bus edge early or late when the bus clock is stepped edge by edge. A restart that fails shows as cmd_ready_o rising about 800 cycles too early after a pulse arrives during the wait.

// File: rtl/hwrq_pkg.sv
package hwrq_pkg;
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/hwrq_sync2.sv
module hwrq_sync2 #(
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/hwrq_filter.sv
module hwrq_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  // level moves only after FILT_CYC consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      lvl_q <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
  assign q_o = lvl_q;
endmodule

// File: rtl/hwrq_ready_gate.sv
module hwrq_ready_gate #(
  parameter int WAIT_CYC   = 40000,
  parameter int BUS_CYCLES = 74
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic bus_edge_i,
  output logic ready_o
);
  localparam int TW = $clog2(WAIT_CYC + 1);
  localparam int BW = $clog2(BUS_CYCLES + 1);
  localparam logic [TW-1:0] T_END = TW'(WAIT_CYC);
  localparam logic [BW-1:0] B_END = BW'(BUS_CYCLES);

  logic [TW-1:0] tmr_q;
  logic [BW-1:0] bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      bcnt_q <= '0;
    end else if (!level_i) begin
      tmr_q  <= '0;
      bcnt_q <= '0;
    end else begin
      if (tmr_q != T_END) tmr_q <= tmr_q + 1'b1;
      if (bus_edge_i && bcnt_q != B_END) bcnt_q <= bcnt_q + 1'b1;
    end
  end
  assign ready_o = (tmr_q == T_END) && (bcnt_q == B_END);
endmodule

// File: rtl/hw_reset_qualifier.sv
module hw_reset_qualifier
  import hwrq_pkg::*;
#(
  parameter int REF_CLK_MHZ = 200,
  parameter int GLITCH_NS   = 5,
  parameter int FILT_MARGIN = 3,
  parameter int WAIT_NS     = 200000,
  parameter int BUS_CYCLES  = 74
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_pin_ni,
  input  logic bus_clk_i,
  output logic reset_trigger_o,
  output logic cmd_ready_o
);
  localparam int GLITCH_CYC = cdiv(GLITCH_NS * REF_CLK_MHZ, 1000);
  localparam int FILT_CYC   = GLITCH_CYC + FILT_MARGIN;
  localparam int WAIT_CYC   = cdiv(WAIT_NS * REF_CLK_MHZ, 1000);

  logic pin_s, filt_lvl, filt_d_q;
  logic bus_s, bus_d_q, bus_edge;

  hwrq_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rst_pin_ni), .q_o(pin_s));

  hwrq_sync2 #(.RST_VAL(1'b0)) u_bus_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_clk_i), .q_o(bus_s));

  hwrq_filter #(.FILT_CYC(FILT_CYC)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_s), .q_o(filt_lvl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_d_q <= 1'b1;
      bus_d_q  <= 1'b0;
    end else begin
      filt_d_q <= filt_lvl;
      bus_d_q  <= bus_s;
    end
  end

  assign bus_edge        = bus_s & ~bus_d_q;
  assign reset_trigger_o = filt_lvl & ~filt_d_q;

  hwrq_ready_gate #(.WAIT_CYC(WAIT_CYC), .BUS_CYCLES(BUS_CYCLES)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(filt_lvl),
    .bus_edge_i(bus_edge), .ready_o(cmd_ready_o));
endmodule

// File: rtl/hw_reset_qualifier_chk.sv
module hw_reset_qualifier_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_s,
  input logic filt_lvl,
  input logic reset_trigger_o,
  input logic cmd_ready_o
);
  // R4
  trig_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_trigger_o |=> !reset_trigger_o);

  // R8
  trig_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_trigger_o |-> !cmd_ready_o);

  // R6
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_lvl && cmd_ready_o) |=> cmd_ready_o);

  // R9
  low_blocks_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !filt_lvl |=> !cmd_ready_o);

  // R2
  filt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_lvl != $past(filt_lvl)) |-> ($past(pin_s) == filt_lvl));

  // R3
  filt_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_lvl != $past(filt_lvl)) |-> ($past(pin_s, 2) == filt_lvl));
endmodule

bind hw_reset_qualifier hw_reset_qualifier_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pin_s(pin_s), .filt_lvl(filt_lvl),
  .reset_trigger_o(reset_trigger_o), .cmd_ready_o(cmd_ready_o));

// File: tb/hw_reset_qualifier_bench.sv
`timescale 1ns/1ps
module hw_reset_qualifier_bench;
  localparam int WAIT_CYC = 2000;
  localparam int NV = 6;
  localparam int VEC_W[NV] = '{5, 10, 15, 25, 1000, 2000};
  localparam int VEC_T[NV] = '{0, 0, 0, 1, 1, 1};

  logic clk = 1'b0, rst_n = 1'b0, pin_n = 1'b1, bclk = 1'b0;
  logic trig, ready;
  bit   bus_run = 1'b1, done = 1'b0, trig_prev = 1'b0;
  int   bus_pulses = 0, trig_cnt = 0, wide_err = 0;
  int   checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  hw_reset_qualifier #(.WAIT_NS(10000)) u_hw_reset_qualifier (
    .clk_i(clk), .rst_ni(rst_n), .rst_pin_ni(pin_n), .bus_clk_i(bclk),
    .reset_trigger_o(trig), .cmd_ready_o(ready));

  initial forever begin
    if (bus_run || bus_pulses > 0) begin
      #20 bclk = 1'b1;
      #20 bclk = 1'b0;
      if (bus_pulses > 0) bus_pulses--;
    end else #5;
  end

  always @(negedge clk) begin
    if (trig) begin
      trig_cnt++;
      if (trig_prev) wide_err++;
    end
    trig_prev = trig;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_pulse(input int ns);
    @(negedge clk);
    pin_n = 1'b0;
    #(ns * 1.0);
    pin_n = 1'b1;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int t0;
    cyc(5);
    // R1
    chk(trig == 1'b0, "R1 trigger in reset", trig, 0);
    chk(ready == 1'b0, "R1 ready in reset", ready, 0);
    rst_n = 1'b1;
    cyc(WAIT_CYC - 20);
    chk(ready == 1'b0, "R6 ready early after power-on", ready, 0);
    cyc(60);
    chk(ready == 1'b1, "R6 ready after power-on wait", ready, 1);

    // R2 R4 R9: pulse width table
    for (int i = 0; i < NV; i++) begin
      t0 = trig_cnt;
      low_pulse(VEC_W[i]);
      cyc(40);
      chk(trig_cnt - t0 == VEC_T[i], $sformatf("R4/R2 width %0dns triggers", VEC_W[i]),
          trig_cnt - t0, VEC_T[i]);
      if (VEC_T[i] == 0) begin
        chk(ready == 1'b1, $sformatf("R2 ready kept after %0dns glitch", VEC_W[i]), ready, 1);
      end else begin
        chk(ready == 1'b0, $sformatf("R9 ready dropped after %0dns", VEC_W[i]), ready, 0);
        cyc(WAIT_CYC + 60);
      end
    end

    // R5 R3: long low with a high glitch inside
    t0 = trig_cnt;
    @(negedge clk);
    pin_n = 1'b0;
    cyc(200);
    pin_n = 1'b1;
    #5;
    pin_n = 1'b0;
    cyc(300);
    chk(trig_cnt == t0, "R3/R5 no trigger during low with high glitch", trig_cnt - t0, 0);
    chk(ready == 1'b0, "R9 ready low while pin low", ready, 0);
    pin_n = 1'b1;
    cyc(20);
    chk(trig_cnt - t0 == 1, "R3 single trigger on final release", trig_cnt - t0, 1);

    // R8: restart during the wait
    cyc(1000);
    t0 = trig_cnt;
    low_pulse(1000);
    cyc(1500);
    chk(ready == 1'b0, "R8 ready still low after restart", ready, 0);
    cyc(WAIT_CYC - 1500 + 40);
    chk(ready == 1'b1, "R8 ready after restarted wait", ready, 1);
    chk(trig_cnt - t0 == 1, "R8 restart trigger count", trig_cnt - t0, 1);

    // R7: bus clock edge count
    bus_run = 1'b0;
    #100;
    low_pulse(1000);
    cyc(WAIT_CYC + 100);
    chk(ready == 1'b0, "R7 ready low without bus clock", ready, 0);
    bus_pulses = 73;
    wait (bus_pulses == 0);
    cyc(20);
    chk(ready == 1'b0, "R7 ready low after 73 bus edges", ready, 0);
    bus_pulses = 1;
    wait (bus_pulses == 0);
    cyc(20);
    chk(ready == 1'b1, "R7 ready after 74th bus edge", ready, 1);

    // R4 width
    chk(wide_err == 0, "R4 trigger one cycle wide", wide_err, 0);
    // R1 again mid-run
    rst_n = 1'b0;
    cyc(3);
    chk(ready == 1'b0 && trig == 1'b0, "R1 outputs cleared by block reset", ready, 0);
    done = 1'b1;
    summary();
  end
endmodule